// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block sits beside the bit-level engine of a CAN controller and decides which operating mode is in force: normal bus operation, a debug halt (freeze), a low-power disabled mode, and an internal loop-back self-test path. Requests arrive as plain control bits. The sequencer lets a change take effect only at a point on the bus where it is safe, and only once the engine reports that its internal work has drained. The engine supplies bus idle, intermission position, error-passive, bus-off, busy and bit-sample strobe inputs.

From its state the sequencer drives the prescaler enable, the clock gate, the Tx pin override and the receiver source. It also drives the not-ready, freeze and low-power acknowledge flags, error-counter write permission, and blocking of private-resource accesses. After a halt, a disable or a reset, the controller stays off the bus until it has seen eleven consecutive recessive sampled bits.

All pins are level control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `can_mode_seq`

## Requirements
- R1: A freeze is requested while `brk_req` or `halt_req` is 1. The frozen mode is left only when both are 0; the controller then enters resynchronisation (not_ready stays 1, frz_ack returns to 0).
- R2: From normal operation, freeze takes effect only after a safe point has been seen (`bus_idle`, `in_imsn`, `err_passive` or `bus_off` is 1) and `core_busy` is 0. While `core_busy` stays 1, `frz_ack` stays 0.
- R3: While frozen: presc_en=0, tx_pin=1, rx_core=1, not_ready=1, frz_ack=1 and lp_ack=0.
- R4: `ecnt_wr_en` is 1 exactly while frozen and 0 in every other mode.
- R5: After reset, after freeze is left, or after disable is cleared without a pending freeze, not_ready stays 1. It clears only after 11 consecutive cycles with `bit_tick`=1 and the receiver input `rx_core`=1. A tick with `rx_core`=0 restarts the count. Cycles without a tick neither count nor restart it.
- R6: Raising `dis_req` while frozen gives clk_en=0, lp_ack=1 and frz_ack=0 on the next cycle.
- R7: Raising `dis_req` during normal operation waits for one of three safe points: `bus_idle`, `bus_off`, or `in_imsn`=1 with `imsn_idx`=2 and a tick that samples `rx_core`=1. A tick at `imsn_idx`=1, or one that samples 0, does not qualify. After the safe point, the sequencer also waits for `core_busy`=0.
- R8: While disabled: clk_en=0, presc_en=0, acc_block=1, tx_pin=1, rx_core=1 and not_ready=1.
- R9: Clearing `dis_req` restores clk_en=1 and lp_ack=0 on the next cycle. The block returns to frozen if a freeze is still requested, and otherwise enters resynchronisation.
- R10: With `lpb_req`=1 and not frozen or disabled, tx_pin=1 and rx_core equals `tx_bit`. Freeze and disable take priority: rx_core=1 then.
- R11: A freeze or disable request that is withdrawn before it takes effect leaves the controller in normal operation (not_ready=0, both acks 0), even when a safe point follows.
- R12: When disable and freeze are both requested during normal operation, the disable path is taken: lp_ack becomes 1 and frz_ack stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| brk_req | input | 1 | External breakpoint freeze request |
| halt_req | input | 1 | Halt control bit freeze request |
| dis_req | input | 1 | Disable (low-power) control bit |
| lpb_req | input | 1 | Loop-back select |
| bus_idle | input | 1 | Engine reports bus idle |
| in_imsn | input | 1 | Engine is in intermission |
| imsn_idx | input | 2 | Intermission bit index (0..2) |
| err_passive | input | 1 | Controller is error-passive |
| bus_off | input | 1 | Controller is bus-off |
| core_busy | input | 1 | Arbitration, matching or buffer moves in progress |
| bit_tick | input | 1 | One-cycle strobe at each bit sample point |
| rx_pin | input | 1 | External receive pin |
| tx_bit | input | 1 | Transmitter bit stream |
| presc_en | output | 1 | Bit-time prescaler enable |
| clk_en | output | 1 | Module clock gate enable |
| tx_pin | output | 1 | Transmit pin (1 = recessive) |
| rx_core | output | 1 | Receive bit delivered to the engine |
| not_ready | output | 1 | Controller is not taking part on the bus |
| frz_ack | output | 1 | Freeze acknowledge |
| lp_ack | output | 1 | Low-power acknowledge |
| ecnt_wr_en | output | 1 | Error counters writable |
| acc_block | output | 1 | Timer, error-counter and buffer accesses blocked |

## Verification
The sequencer is driven with directed requests placed against different bus conditions. A safe point with the busy flag still high separates waiting for a safe point from waiting for the drain. Third-intermission ticks that are dominant, or land at the wrong index, show whether disable uses its narrower safe set or freeze's wider one. Resynchronisation runs are broken by a dominant tick, which shows whether the count restarts or merely pauses. Long random stretches then toggle every request and status input. On every cycle they are compared with a behavioural model, which exposes priority errors between disable, freeze and loop-back.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MS_RUN       = 3'd0,
    MS_FRZ_WAIT  = 3'd1,
    MS_FRZ_DRAIN = 3'd2,
    MS_FROZEN    = 3'd3,
    MS_DIS_WAIT  = 3'd4,
    MS_DIS_DRAIN = 3'd5,
    MS_OFF       = 3'd6,
    MS_RESYNC    = 3'd7
  } mode_t;
endpackage

// File: rtl/can_mode_safept.sv
module can_mode_safept #(
  parameter int IMSN_W    = 2,
  parameter int IMSN_LAST = 2
) (
  input  logic              bus_idle,
  input  logic              in_imsn,
  input  logic [IMSN_W-1:0] imsn_idx,
  input  logic              err_passive,
  input  logic              bus_off,
  input  logic              bit_tick,
  input  logic              rx_core,
  output logic              frz_safe,
  output logic              dis_safe
);
  localparam logic [IMSN_W-1:0] LastIdx = IMSN_W'(IMSN_LAST);

  logic last_imsn_recessive;

  always_comb begin
    last_imsn_recessive = in_imsn && (imsn_idx == LastIdx) && bit_tick && rx_core;
    frz_safe = bus_idle || in_imsn || err_passive || bus_off;
    dis_safe = bus_idle || bus_off || last_imsn_recessive;
  end
endmodule

// File: rtl/can_mode_resync.sv
module can_mode_resync #(
  parameter int BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_tick,
  input  logic rx,
  output logic done
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LastCnt = CW'(BITS - 1);

  logic [CW-1:0] cnt_q;

  assign done = active && bit_tick && rx && (cnt_q == LastCnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!active)         cnt_q <= '0;
    else if (bit_tick) begin
      if (!rx || done)        cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: count never runs past the last recessive bit
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LastCnt);

  // R5: a dominant sample restarts the count
  p_dominant_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && bit_tick && !rx) |=> (cnt_q == '0));
endmodule

// File: rtl/can_mode_pinmux.sv
module can_mode_pinmux (
  input  logic halted,
  input  logic tx_quiet,
  input  logic lpb_req,
  input  logic tx_bit,
  input  logic rx_pin,
  output logic tx_pin,
  output logic rx_core
);
  always_comb begin
    tx_pin  = (halted || tx_quiet || lpb_req) ? 1'b1 : tx_bit;
    if (halted)       rx_core = 1'b1;
    else if (lpb_req) rx_core = tx_bit;
    else              rx_core = rx_pin;
  end
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int RESYNC_BITS = 11,
  parameter int IMSN_W      = 2,
  parameter int IMSN_LAST   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              brk_req,
  input  logic              halt_req,
  input  logic              dis_req,
  input  logic              lpb_req,
  input  logic              bus_idle,
  input  logic              in_imsn,
  input  logic [IMSN_W-1:0] imsn_idx,
  input  logic              err_passive,
  input  logic              bus_off,
  input  logic              core_busy,
  input  logic              bit_tick,
  input  logic              rx_pin,
  input  logic              tx_bit,
  output logic              presc_en,
  output logic              clk_en,
  output logic              tx_pin,
  output logic              rx_core,
  output logic              not_ready,
  output logic              frz_ack,
  output logic              lp_ack,
  output logic              ecnt_wr_en,
  output logic              acc_block
);
  mode_t state_q, state_d;
  logic  frz_req, frz_safe, dis_safe, resync_done;
  logic  halted, in_resync;

  assign frz_req   = brk_req || halt_req;
  assign halted    = (state_q == MS_FROZEN) || (state_q == MS_OFF);
  assign in_resync = (state_q == MS_RESYNC);

  can_mode_pinmux u_pinmux (
    .halted   (halted),
    .tx_quiet (in_resync),
    .lpb_req  (lpb_req),
    .tx_bit   (tx_bit),
    .rx_pin   (rx_pin),
    .tx_pin   (tx_pin),
    .rx_core  (rx_core)
  );

  can_mode_safept #(.IMSN_W(IMSN_W), .IMSN_LAST(IMSN_LAST)) u_safept (
    .bus_idle    (bus_idle),
    .in_imsn     (in_imsn),
    .imsn_idx    (imsn_idx),
    .err_passive (err_passive),
    .bus_off     (bus_off),
    .bit_tick    (bit_tick),
    .rx_core     (rx_core),
    .frz_safe    (frz_safe),
    .dis_safe    (dis_safe)
  );

  can_mode_resync #(.BITS(RESYNC_BITS)) u_resync (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (in_resync),
    .bit_tick (bit_tick),
    .rx       (rx_core),
    .done     (resync_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MS_RUN: begin
        if (dis_req)      state_d = MS_DIS_WAIT;
        else if (frz_req) state_d = MS_FRZ_WAIT;
      end
      MS_FRZ_WAIT: begin
        if (!frz_req)       state_d = MS_RUN;
        else if (frz_safe)  state_d = core_busy ? MS_FRZ_DRAIN : MS_FROZEN;
      end
      MS_FRZ_DRAIN: begin
        if (!frz_req)       state_d = MS_RUN;
        else if (!core_busy) state_d = MS_FROZEN;
      end
      MS_FROZEN: begin
        if (dis_req)       state_d = MS_OFF;
        else if (!frz_req) state_d = MS_RESYNC;
      end
      MS_DIS_WAIT: begin
        if (!dis_req)      state_d = MS_RUN;
        else if (dis_safe) state_d = core_busy ? MS_DIS_DRAIN : MS_OFF;
      end
      MS_DIS_DRAIN: begin
        if (!dis_req)        state_d = MS_RUN;
        else if (!core_busy) state_d = MS_OFF;
      end
      MS_OFF: begin
        if (!dis_req) state_d = frz_req ? MS_FROZEN : MS_RESYNC;
      end
      MS_RESYNC: begin
        if (dis_req)          state_d = MS_OFF;
        else if (frz_req)     state_d = MS_FROZEN;
        else if (resync_done) state_d = MS_RUN;
      end
      default: state_d = MS_RESYNC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MS_RESYNC;
    else        state_q <= state_d;
  end

  always_comb begin
    presc_en   = !halted;
    clk_en     = (state_q != MS_OFF);
    lp_ack     = (state_q == MS_OFF);
    frz_ack    = (state_q == MS_FROZEN);
    ecnt_wr_en = (state_q == MS_FROZEN);
    acc_block  = (state_q == MS_OFF);
    not_ready  = halted || in_resync;
  end

  // R3/R6: freeze and low-power acknowledge never together
  p_ack_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frz_ack && lp_ack));

  // R4: counter write permission only with freeze acknowledged
  p_ecnt_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ecnt_wr_en |-> (frz_ack && !presc_en));

  // R2: entering freeze from the wait path requires drained activity
  p_frz_drained_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frz_ack) && $past(state_q == MS_FRZ_WAIT || state_q == MS_FRZ_DRAIN))
      |-> $past(!core_busy));

  // R3/R8: halted modes keep Tx recessive
  p_tx_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_ack || lp_ack) |-> (tx_pin && rx_core));

  // R8: low-power means gated clocks and blocked accesses
  p_off_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lp_ack |-> (!clk_en && acc_block && not_ready));

  // R5: rejoining the bus only on a recessive sample tick
  p_rejoin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(not_ready) |-> $past(bit_tick && rx_core));

  // R6: disable while frozen acts on the next cycle
  p_off_from_frz_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_ack && dis_req) |=> lp_ack);
endmodule

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic brk_req = 0, halt_req = 0, dis_req = 0, lpb_req = 0;
  logic bus_idle = 0, in_imsn = 0, err_passive = 0, bus_off = 0, core_busy = 0;
  logic [1:0] imsn_idx = 2'd0;
  logic bit_tick = 0, rx_pin = 1, tx_bit = 1;
  logic presc_en, clk_en, tx_pin, rx_core, not_ready, frz_ack, lp_ack, ecnt_wr_en, acc_block;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .brk_req(brk_req), .halt_req(halt_req),
    .dis_req(dis_req), .lpb_req(lpb_req), .bus_idle(bus_idle), .in_imsn(in_imsn),
    .imsn_idx(imsn_idx), .err_passive(err_passive), .bus_off(bus_off),
    .core_busy(core_busy), .bit_tick(bit_tick), .rx_pin(rx_pin), .tx_bit(tx_bit),
    .presc_en(presc_en), .clk_en(clk_en), .tx_pin(tx_pin), .rx_core(rx_core),
    .not_ready(not_ready), .frz_ack(frz_ack), .lp_ack(lp_ack),
    .ecnt_wr_en(ecnt_wr_en), .acc_block(acc_block)
  );

  // behavioural reference: mode names as small integers
  localparam int M_ACTIVE = 0, M_WFRZ = 1, M_WDIS = 2, M_FRZ = 3, M_OFF = 4, M_SYNC = 5;
  int m_mode = M_SYNC;
  int m_run_len = 0;
  bit m_frz_seen = 0;
  bit m_dis_seen = 0;

  task automatic chk(input logic act, input logic exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_halted();
    return (m_mode == M_FRZ) || (m_mode == M_OFF);
  endfunction

  function automatic logic m_rx();
    if (m_halted()) return 1'b1;
    if (lpb_req) return tx_bit;
    return rx_pin;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = M_SYNC; m_run_len = 0; m_frz_seen = 0; m_dis_seen = 0;
    end else begin
      bit fr, rx, dsafe, fsafe;
      fr = brk_req | halt_req;
      rx = m_rx();
      fsafe = bus_idle | in_imsn | err_passive | bus_off;
      dsafe = bus_idle | bus_off | (in_imsn && imsn_idx == 2'd2 && bit_tick && rx);
      if (m_mode == M_ACTIVE) begin
        m_frz_seen = 0; m_dis_seen = 0;
        if (dis_req) m_mode = M_WDIS;
        else if (fr) m_mode = M_WFRZ;
      end else if (m_mode == M_WFRZ) begin
        if (!fr) m_mode = M_ACTIVE;
        else begin
          if (fsafe) m_frz_seen = 1;
          if (m_frz_seen && !core_busy) m_mode = M_FRZ;
        end
      end else if (m_mode == M_WDIS) begin
        if (!dis_req) m_mode = M_ACTIVE;
        else begin
          if (dsafe) m_dis_seen = 1;
          if (m_dis_seen && !core_busy) m_mode = M_OFF;
        end
      end else if (m_mode == M_FRZ) begin
        if (dis_req) m_mode = M_OFF;
        else if (!fr) begin m_mode = M_SYNC; m_run_len = 0; end
      end else if (m_mode == M_OFF) begin
        if (!dis_req) begin
          m_mode = fr ? M_FRZ : M_SYNC; m_run_len = 0;
        end
      end else begin
        if (dis_req) m_mode = M_OFF;
        else if (fr) m_mode = M_FRZ;
        else if (bit_tick) begin
          if (rx) m_run_len++;
          else m_run_len = 0;
          if (m_run_len == 11) begin m_mode = M_ACTIVE; m_run_len = 0; end
        end
      end
    end
  end

  // compare every cycle, well after the input changes at the falling edge
  always @(negedge clk) begin
    #3;
    if (rst_n && !finished) begin
      bit h;
      h = m_halted();
      chk(presc_en,   !h,                  "R3 presc_en");
      chk(clk_en,     m_mode != M_OFF,     "R8 clk_en");
      chk(acc_block,  m_mode == M_OFF,     "R8 acc_block");
      chk(tx_pin,     (h || m_mode == M_SYNC || lpb_req) ? 1'b1 : tx_bit, "R10 tx_pin");
      chk(rx_core,    m_rx(),              "R10 rx_core");
      chk(not_ready,  h || m_mode == M_SYNC, "R5 not_ready");
      chk(frz_ack,    m_mode == M_FRZ,     "R3 frz_ack");
      chk(lp_ack,     m_mode == M_OFF,     "R6 lp_ack");
      chk(ecnt_wr_en, m_mode == M_FRZ,     "R4 ecnt_wr_en");
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input logic rxv);
    bit_tick = 1; rx_pin = rxv; step(1);
    bit_tick = 0; rx_pin = 1;   step(1);
  endtask

  task automatic resync();
    for (int i = 0; i < 11; i++) tick(1'b1);
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    chk(not_ready, 1, "R5 reset not_ready");
    chk(frz_ack, 0, "R3 reset frz_ack");
    chk(lp_ack, 0, "R6 reset lp_ack");
    chk(clk_en, 1, "R8 reset clk_en");

    // R5: dominant tick restarts the count
    for (int i = 0; i < 5; i++) tick(1'b1);
    tick(1'b0);
    for (int i = 0; i < 10; i++) tick(1'b1);
    chk(not_ready, 1, "R5 ten after restart");
    tick(1'b1);
    chk(not_ready, 0, "R5 eleventh recessive");

    // R2: safe point but busy
    halt_req = 1; bus_idle = 1; core_busy = 1;
    step(4);
    chk(frz_ack, 0, "R2 busy holds off freeze");
    core_busy = 0;
    step(2);
    chk(frz_ack, 1, "R2 frozen after drain");
    chk(presc_en, 0, "R3 prescaler off");
    chk(ecnt_wr_en, 1, "R4 counters writable");

    // R1: breakpoint alone keeps freeze
    halt_req = 0; brk_req = 1;
    step(2);
    chk(frz_ack, 1, "R1 breakpoint holds freeze");
    brk_req = 0;
    step(2);
    chk(frz_ack, 0, "R1 freeze left");
    chk(not_ready, 1, "R1 resync after freeze");

    // R6 / R9
    halt_req = 1;
    step(2);
    chk(frz_ack, 1, "R1 re-freeze from resync");
    dis_req = 1;
    step(1);
    chk(lp_ack, 1, "R6 lp_ack next cycle");
    chk(frz_ack, 0, "R6 frz_ack cleared");
    chk(acc_block, 1, "R8 accesses blocked");
    dis_req = 0;
    step(1);
    chk(clk_en, 1, "R9 clocks restored");
    chk(frz_ack, 1, "R9 back to freeze");
    halt_req = 0;
    step(2);
    resync();
    chk(not_ready, 0, "R5 back on bus");

    // R11: withdrawn freeze
    bus_idle = 0; halt_req = 1;
    step(3);
    halt_req = 0;
    step(1);
    bus_idle = 1;
    step(3);
    chk(frz_ack, 0, "R11 withdrawn freeze");
    chk(not_ready, 0, "R11 still active");

    // R7: disable safe points
    bus_idle = 0; dis_req = 1;
    step(3);
    chk(lp_ack, 0, "R7 no safe point yet");
    in_imsn = 1; imsn_idx = 2'd1;
    tick(1'b1);
    chk(lp_ack, 0, "R7 second intermission bit");
    imsn_idx = 2'd2;
    tick(1'b0);
    chk(lp_ack, 0, "R7 dominant third bit");
    tick(1'b1);
    chk(lp_ack, 1, "R7 recessive third bit");
    dis_req = 0; in_imsn = 0; imsn_idx = 2'd0;
    step(1);
    chk(lp_ack, 0, "R9 lp_ack cleared");
    resync();

    // R12: both requested
    halt_req = 1; dis_req = 1; bus_idle = 1;
    step(3);
    chk(lp_ack, 1, "R12 disable wins");
    chk(frz_ack, 0, "R12 no freeze ack");
    dis_req = 0;
    step(1);
    chk(frz_ack, 1, "R9 freeze after enable");
    halt_req = 0;
    step(2);
    resync();

    // R10: loop-back
    lpb_req = 1; tx_bit = 0; rx_pin = 1;
    step(1);
    chk(tx_pin, 1, "R10 tx held recessive");
    chk(rx_core, 0, "R10 rx from tx stream");
    halt_req = 1;
    step(3);
    chk(rx_core, 1, "R10 freeze overrides loop-back");
    halt_req = 0; lpb_req = 0; tx_bit = 1; bus_idle = 0;
    step(2);

    // random phase, model compared every cycle
    for (int c = 0; c < 6000; c++) begin
      if ($urandom_range(0, 99) < 3) halt_req = ~halt_req;
      if ($urandom_range(0, 99) < 2) brk_req = ~brk_req;
      if ($urandom_range(0, 99) < 2) dis_req = ~dis_req;
      if ($urandom_range(0, 99) < 2) lpb_req = ~lpb_req;
      bus_idle    = ($urandom_range(0, 99) < 10);
      in_imsn     = ($urandom_range(0, 99) < 20);
      imsn_idx    = 2'($urandom_range(0, 2));
      err_passive = ($urandom_range(0, 99) < 5);
      bus_off     = ($urandom_range(0, 99) < 3);
      core_busy   = ($urandom_range(0, 99) < 40);
      bit_tick    = ($urandom_range(0, 3) == 0);
      rx_pin      = ($urandom_range(0, 99) < 92);
      tx_bit      = ($urandom_range(0, 99) < 90);
      step(1);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule